// File: doc/BRIEF.md
# Block Write-Protection Guard with Status Register

This block sits inside a serial memory's command logic and owns the protection state of a byte array. It holds three retained bits and two live bits. The retained bits are a two-bit protection level and a pin-lock enable. The live bits are a write-permit latch and a busy flag. From these bits and the external lock pin it decides whether an array address may be written and whether the protection bits themselves may be rewritten. It also returns the status byte that a read-status command shifts out.

The command decoder drives single-cycle strobes into the block. These set or clear the permit latch, stage a new status value, or stage an array write. A commit strobe at the end of the frame launches the staged operation. That operation uses one self-timed cycle of `WR_CYCLES` clocks. At the end of the cycle the retained bits take their staged value (for a status write) and the permit latch drops. The retained bits come out of reset at the value `NV_INIT`, which stands for what the storage kept across power loss.

Top module: `wp_status_guard`

## Requirements
- R1: After reset, busy is 0 and the permit latch is 0. The status byte reads {NV_INIT[2], 000, NV_INIT[1:0], 0, 0}.
- R2: When idle, the status byte is: bit 7 = lock enable, bits 6..4 = 0, bits 3..2 = protection level, bit 1 = permit latch, bit 0 = 0.
- R3: Busy rises one cycle after a commit that launches an operation and stays high for exactly WR_CYCLES cycles. While busy, the status byte reads 8'hFF.
- R4: With AW address bits, `arr_ok` is 0 for every protected address. Level 0 protects nothing. Level 1 protects the top quarter (the two top address bits both 1). Level 2 protects the top half (top bit 1). Level 3 protects every address.
- R5: `arr_ok` is 1 only when the permit latch is 1, the block is idle and the address is unprotected. The lock pin does not affect it.
- R6: `clr_wel` clears the permit latch whatever the pin level. `set_wel` sets it only while `lock_n` is high.
- R7: `sr_ok` is 1 only when the block is idle, the permit latch is 1, and not (lock enable = 1 and `lock_n` low). With lock enable 0, the pin has no effect.
- R8: A staged status write changes the retained bits only at the end of its cycle. Every completed cycle clears the permit latch.
- R9: If `lock_n` is low while lock enable is 1 and a status write is staged but not committed, the write is dropped: no cycle starts and the bits keep their value. A pin change during a running cycle has no effect on it.
- R10: While busy, `sr_ok` and `arr_ok` read 0 and staging strobes are ignored, so a later commit launches nothing.
- R11: Values written to status bits 6..4, 1 and 0 are discarded; those bits read back as 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_n | input | 1 | External lock pin, active low |
| set_wel | input | 1 | Strobe: set the permit latch |
| clr_wel | input | 1 | Strobe: clear the permit latch |
| sr_stage | input | 1 | Strobe: stage a status write of `sr_wdata` |
| sr_wdata | input | 8 | Status value to stage |
| arr_start | input | 1 | Strobe: stage an array write at `arr_addr` |
| arr_addr | input | AW | Array address being checked or staged |
| commit | input | 1 | Frame-end strobe that launches the staged operation |
| arr_ok | output | 1 | Array write at `arr_addr` is permitted |
| sr_ok | output | 1 | Status write is permitted |
| busy | output | 1 | Self-timed cycle in progress |
| status_byte | output | 8 | Status byte for the read-status command |

## Verification
The bench builds the block with AW = 6, WR_CYCLES = 4 and NV_INIT = 3'b101. The 6-bit space makes a full sweep possible: each of the 64 addresses is checked under all four protection levels and both permit-latch states, against a boundary computed in the bench. The short cycle lets the bench count busy edge by edge. The non-zero reset value exercises the pin lock and the cancel path straight out of reset.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_SR   = 2'd1,
      OP_ARR  = 2'd2
   } pend_e;

   typedef struct packed {
      logic       lock_en;
      logic [1:0] level;
   } nv_t;

endpackage

// File: rtl/wp_zone_decode.sv
module wp_zone_decode #(
   parameter int AW = 15
) (
   input  logic [1:0]    level,
   input  logic [AW-1:0] addr,
   output logic          hit
);
   generate
      if (AW < 3) begin : g_bad_aw
         $error("wp_zone_decode: AW must be at least 3");
      end
   endgenerate

   localparam int TOP = AW - 1;

   logic unused_low;
   assign unused_low = ^addr[AW-3:0];

   always_comb begin
      unique case (level)
         2'd0:    hit = 1'b0;
         2'd1:    hit = addr[TOP] & addr[TOP-1];
         2'd2:    hit = addr[TOP];
         default: hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/wp_cycle_timer.sv
module wp_cycle_timer #(
   parameter int CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);
   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("wp_cycle_timer: CYC must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYC);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start && cnt_q == '0)
         cnt_q <= LOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - ONE;
   end

   assign busy = (cnt_q != '0);
   assign last = (cnt_q == ONE);

   assert_timer_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (cnt_q == LOAD));

   assert_timer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
   import wp_guard_pkg::*;
#(
   parameter int       AW        = 15,
   parameter int       WR_CYCLES = 1000,
   parameter logic [2:0] NV_INIT = 3'b000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock_n,
   input  logic          set_wel,
   input  logic          clr_wel,
   input  logic          sr_stage,
   input  logic [7:0]    sr_wdata,
   input  logic          arr_start,
   input  logic [AW-1:0] arr_addr,
   input  logic          commit,
   output logic          arr_ok,
   output logic          sr_ok,
   output logic          busy,
   output logic [7:0]    status_byte
);
   nv_t   nv_q, stage_q;
   logic  wel_q;
   pend_e pend_q, run_q;
   logic  cyc_last, zone_hit, hw_lock, sr_cancel, launch;

   logic unused_wbits;
   assign unused_wbits = ^{sr_wdata[6:4], sr_wdata[1:0]};

   wp_zone_decode #(.AW(AW)) u_zone (
      .level (nv_q.level),
      .addr  (arr_addr),
      .hit   (zone_hit)
   );

   wp_cycle_timer #(.CYC(WR_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (launch),
      .busy  (busy),
      .last  (cyc_last)
   );

   assign hw_lock   = nv_q.lock_en & ~lock_n;
   assign sr_ok     = ~busy & wel_q & ~hw_lock;
   assign arr_ok    = ~busy & wel_q & ~zone_hit;
   assign sr_cancel = (pend_q == OP_SR) & hw_lock;
   assign launch    = ~busy & commit &
                      ((pend_q == OP_ARR) | ((pend_q == OP_SR) & ~sr_cancel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_q    <= nv_t'(NV_INIT);
         stage_q <= nv_t'(NV_INIT);
         wel_q   <= 1'b0;
         pend_q  <= OP_NONE;
         run_q   <= OP_NONE;
      end else if (busy) begin
         pend_q <= OP_NONE;
         if (cyc_last) begin
            wel_q <= 1'b0;
            if (run_q == OP_SR) nv_q <= stage_q;
            run_q <= OP_NONE;
         end
      end else begin
         if (launch) run_q <= pend_q;
         if (commit || sr_cancel)
            pend_q <= OP_NONE;
         else if (sr_stage && sr_ok) begin
            pend_q  <= OP_SR;
            stage_q <= '{lock_en: sr_wdata[7], level: sr_wdata[3:2]};
         end else if (arr_start && arr_ok)
            pend_q <= OP_ARR;
         if (clr_wel)
            wel_q <= 1'b0;
         else if (set_wel && lock_n)
            wel_q <= 1'b1;
      end
   end

   assign status_byte = busy ? 8'hFF : {nv_q.lock_en, 3'b000, nv_q.level, wel_q, 1'b0};

   assert_wel_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel_q);

   assert_nv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_last |=> $stable(nv_q));

   assert_set_needs_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wel_q && set_wel && !lock_n) |=> !wel_q);

   assert_clr_any_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && clr_wel) |=> !wel_q);

   assert_busy_no_stage_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (pend_q == OP_NONE));

   assert_full_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_q.level == 2'b11) |-> !arr_ok);
endmodule

// File: tb/sim_wp_status_guard.sv
`timescale 1ns/1ps
module sim_wp_status_guard;
   localparam int AW = 6;
   localparam int WRC = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lock_n = 1'b1, set_wel = 0, clr_wel = 0, sr_stage = 0, arr_start = 0, commit = 0;
   logic [7:0] sr_wdata = '0;
   logic [AW-1:0] arr_addr = '0;
   logic arr_ok, sr_ok, busy;
   logic [7:0] status_byte;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wp_status_guard #(.AW(AW), .WR_CYCLES(WRC), .NV_INIT(3'b101)) u0 (
      .clk(clk), .rst_n(rst_n), .lock_n(lock_n), .set_wel(set_wel), .clr_wel(clr_wel),
      .sr_stage(sr_stage), .sr_wdata(sr_wdata), .arr_start(arr_start), .arr_addr(arr_addr),
      .commit(commit), .arr_ok(arr_ok), .sr_ok(sr_ok), .busy(busy), .status_byte(status_byte));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic pulse_set();
      set_wel = 1; step(); set_wel = 0;
   endtask

   task automatic pulse_clr();
      clr_wel = 1; step(); clr_wel = 0;
   endtask

   // commit, then follow the cycle edge by edge (R3, R8)
   task automatic run_cycle(input logic [7:0] exp_after);
      commit = 1; step(); commit = 0;
      chk("R3 status FF while busy", status_byte, 8'hFF);
      repeat (WRC - 1) step();
      chk("R3 busy in last cycle", busy, 1);
      step();
      chk("R3 busy ends after WR_CYCLES", busy, 0);
      chk("R8 status after cycle", status_byte, exp_after);
   endtask

   task automatic write_sr(input logic [7:0] d);
      pulse_set();
      sr_wdata = d; sr_stage = 1; step(); sr_stage = 0;
      run_cycle({d[7], 3'b000, d[3:2], 2'b00});
   endtask

   function automatic logic exp_prot(input int lvl, input int a);
      case (lvl)
         0: exp_prot = 1'b0;
         1: exp_prot = (a >= 48);
         2: exp_prot = (a >= 32);
         default: exp_prot = 1'b1;
      endcase
   endfunction

   initial begin
      repeat (3) step();
      rst_n = 1; step();
      // R1 reset state: lock_en=1, level=01
      chk("R1 reset status", status_byte, 8'h84);
      chk("R1 reset busy", busy, 0);
      chk("R7 sr_ok without latch", sr_ok, 0);
      pulse_set();
      chk("R2 latch in bit 1", status_byte, 8'h86);
      chk("R7 sr_ok pin high", sr_ok, 1);
      // R6 pin level on set/clear
      lock_n = 0; pulse_clr();
      chk("R6 clear with pin low", status_byte, 8'h84);
      pulse_set();
      chk("R6 set ignored with pin low", status_byte, 8'h84);
      lock_n = 1; pulse_set(); lock_n = 0; #1;
      chk("R7 hw lock blocks status write", sr_ok, 0);
      arr_addr = 6'd0; #1;
      chk("R5 unprotected address under hw lock", arr_ok, 1);
      arr_addr = 6'd63; #1;
      chk("R4 level 1 top address", arr_ok, 0);
      // R9 cancel by pin fall between stage and commit
      lock_n = 1; sr_wdata = 8'h00; sr_stage = 1; step(); sr_stage = 0;
      lock_n = 0; step();
      commit = 1; step(); commit = 0;
      chk("R9 cancelled write starts no cycle", busy, 0);
      chk("R9 bits unchanged", status_byte, 8'h86);
      // R9 pin fall during running cycle, R11 unused bits
      lock_n = 1; sr_wdata = 8'hFF; sr_stage = 1; step(); sr_stage = 0;
      commit = 1; step(); commit = 0;
      chk("R3 status FF", status_byte, 8'hFF);
      lock_n = 0;
      repeat (WRC) step();
      chk("R9 R11 write completes despite pin", status_byte, 8'h8C);
      lock_n = 1;
      write_sr(8'h00);
      // R7 with lock enable 0 the pin does nothing
      pulse_set(); lock_n = 0; #1;
      chk("R7 pin ignored when lock enable 0", sr_ok, 1);
      sr_wdata = 8'h08; sr_stage = 1; step(); sr_stage = 0;
      run_cycle(8'h08);
      lock_n = 1;
      // R4 R5 sweep of every address, level and latch state
      for (int lvl = 0; lvl < 4; lvl++) begin
         write_sr(8'(lvl << 2));
         for (int w = 0; w < 2; w++) begin
            if (w == 1) pulse_set(); else pulse_clr();
            chk("R2 status in sweep", status_byte, 8'((lvl << 2) | (w << 1)));
            for (int a = 0; a < 64; a++) begin
               arr_addr = 6'(a); #1;
               chk("R4 R5 arr_ok sweep", arr_ok, (w == 1) && !exp_prot(lvl, a));
            end
         end
      end
      // R8 R10 array write cycle, staging ignored while busy
      write_sr(8'h00);
      pulse_set(); arr_addr = 6'd5; arr_start = 1; step(); arr_start = 0;
      commit = 1; step(); commit = 0;
      chk("R3 array cycle busy", busy, 1);
      chk("R10 arr_ok low while busy", arr_ok, 0);
      chk("R10 sr_ok low while busy", sr_ok, 0);
      sr_wdata = 8'h0C; sr_stage = 1; step(); sr_stage = 0;
      repeat (WRC) step();
      chk("R8 latch cleared after array cycle", status_byte, 8'h00);
      commit = 1; step(); commit = 0;
      chk("R10 staging during busy was dropped", busy, 0);
      // R4 staging to protected address launches nothing
      write_sr(8'h0C);
      pulse_set(); arr_addr = 6'd0; arr_start = 1; step(); arr_start = 0;
      commit = 1; step(); commit = 0;
      chk("R4 protected array write no cycle", busy, 0);
      chk("R4 status unchanged", status_byte, 8'h0E);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule